// File: doc/BRIEF.md
# Reversible Twisted-Ring Multiphase Generator

This block steps a twisted-ring shift register, in which the complemented far-end stage feeds the near-end stage, so an n-stage ring walks through 2n distinct patterns before repeating. One shared step pulse advances three such rings together: a main ring of configurable length, a three-stage ring and a two-stage ring. Each step takes one clock, so the output rate follows the clock rate and the step enable duty directly.

The raw main-ring pattern is presented as a count. A one-hot strobe vector marks which of its 2n positions the ring holds, each strobe found by ANDing two adjacent stages. The three-stage ring drives three square waves spaced a third of a period apart. The two-stage ring is decoded into four mutually exclusive phase lines, a sequence suited to a two-phase full-step motor driver. A direction input reverses the shift, and with it the order of every sequence. A pattern that is not on the ring's orbit is pulled back to all zeros on the next enabled clock, so the ring cannot lock up.

Top module: `johnson_phase_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next outputs are `count` = 0, `strobe` = 1 (bit 0 only), `phase3` = 3'b100 and `phase4` = 4'b0001, whatever `step_en` and `dir` are.
- R2: On an edge with `step_en` high and `dir` high, `count` shifts towards its MSB: bit 0 (first stage) takes the inverse of bit STAGES-1, and bit k takes the old bit k-1. From zero with STAGES = 4, `count` runs 0000, 0001, 0011, 0111, 1111, 1110, 1100, 1000 and returns to 0000 after 2*STAGES steps.
- R3: On an edge with `step_en` high and `dir` low, `count` shifts towards its LSB: bit STAGES-1 takes the inverse of bit 0, and bit k takes the old bit k+1, retracing the R2 sequence backwards (from 0000 the next value is 1000).
- R4: On an edge with `step_en` low and `rst` low, none of `count`, `strobe`, `phase3` or `phase4` changes, whatever `dir` is.
- R5: `strobe` always has exactly one bit set; bit p is set when `count` is at position p of the R2 sequence counted from zero (p in 0..2*STAGES-1), so bit 0 means all zeros and bit STAGES means all ones.
- R6: `phase3` comes from a three-stage ring with six positions numbered in its forward order from reset; bit 0 is high at positions 1..3, bit 1 at positions 3..5, bit 2 at positions 5, 0 and 1, so the three waves are two positions apart. Forward steps raise the position by one, reverse steps lower it.
- R7: `phase4` always has exactly one bit set. Forward steps move it bit 0, 1, 2, 3, 0; reverse steps move it bit 0, 3, 2, 1, 0.
- R8: After every clock edge `count` is a legal ring pattern (a run of ones from bit 0 upward, or a run of ones from bit STAGES-1 downward, including all zeros and all ones); an illegal pattern is replaced by zero on the next enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Advance all rings by one position on this edge |
| dir | input | 1 | 1 = forward shift, 0 = reverse shift |
| count | output | STAGES | Main ring pattern, bit 0 is the first stage |
| strobe | output | 2*STAGES | One-hot decode of the main ring position |
| phase3 | output | 3 | Three square waves a third of a period apart |
| phase4 | output | 4 | Four non-overlapping quarter-period phase lines |

## Verification
The assertions assume that `rst`, `step_en` and `dir` hold known 0/1 values at every rising edge and that `rst` is high on the first edge, so every ring starts from the zero pattern and stays on its orbit; the stepping and one-hot checks depend on that start. The stimulus drives all three inputs only on falling edges, begins with two reset cycles, and then mixes forward runs long enough to wrap, reverse runs through zero, idle cycles with `dir` toggled, and a reset applied while steps are enabled.

// File: rtl/jpg_pkg.sv
package jpg_pkg;
  // Shift direction encoding seen on the dir input.
  typedef enum logic {
    DIR_REV = 1'b0,
    DIR_FWD = 1'b1
  } step_dir_e;

  // Fixed ring lengths for the phase outputs.
  localparam int PH3_STAGES = 3;
  localparam int PH4_STAGES = 2;
  localparam int PH3_LINES  = 3;
  localparam int PH4_LINES  = 2 * PH4_STAGES;
endpackage

// File: rtl/jpg_twisted_ring.sv
module jpg_twisted_ring
  import jpg_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_en,
  input  logic         dir,
  output logic [W-1:0] q,
  output logic [W-1:0] q_next
);
  logic [W-1:0] q_inv;
  logic         run_low;
  logic         run_high;
  logic         on_orbit;

  // A legal pattern is a block of ones anchored at either end.
  assign q_inv    = ~q;
  assign run_low  = ((q & (q + 1'b1)) == '0);
  assign run_high = ((q_inv & (q_inv + 1'b1)) == '0);
  assign on_orbit = run_low | run_high;

  always_comb begin
    if (!on_orbit) begin
      q_next = '0;
    end else if (step_dir_e'(dir) == DIR_FWD) begin
      q_next = {q[W-2:0], ~q[W-1]};
    end else begin
      q_next = {~q[0], q[W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (step_en) begin
      q <= q_next;
    end
  end
endmodule

// File: rtl/jpg_state_decode.sv
module jpg_state_decode #(
  parameter int W = 4
) (
  input  logic [W-1:0]   v,
  output logic [2*W-1:0] hit
);
  // Each position of a twisted ring is identified by two adjacent stages.
  assign hit[0] = ~v[0] & ~v[W-1];
  assign hit[W] =  v[0] &  v[W-1];

  for (genvar k = 1; k < W; k++) begin : g_pos
    assign hit[k]     =  v[k-1] & ~v[k];
    assign hit[W + k] = ~v[k-1] &  v[k];
  end
endmodule

// File: rtl/johnson_phase_gen.sv
module johnson_phase_gen
  import jpg_pkg::*;
#(
  parameter int STAGES = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                step_en,
  input  logic                dir,
  output logic [STAGES-1:0]   count,
  output logic [2*STAGES-1:0] strobe,
  output logic [2:0]          phase3,
  output logic [3:0]          phase4
);
  localparam int POSITIONS = 2 * STAGES;

  logic [STAGES-1:0]     main_q;
  logic [STAGES-1:0]     main_next;
  logic [POSITIONS-1:0]  main_hit;
  logic [PH3_STAGES-1:0] r3_q;
  logic [PH3_STAGES-1:0] r3_next;
  logic [PH4_STAGES-1:0] r2_q;
  logic [PH4_STAGES-1:0] r2_next;
  logic [PH4_LINES-1:0]  r2_hit;
  logic [PH3_LINES-1:0]  ph3_d;

  jpg_twisted_ring #(.W(STAGES)) u_main_ring (
    .clk     (clk),
    .rst     (rst),
    .step_en (step_en),
    .dir     (dir),
    .q       (main_q),
    .q_next  (main_next)
  );

  jpg_twisted_ring #(.W(PH3_STAGES)) u_ring3 (
    .clk     (clk),
    .rst     (rst),
    .step_en (step_en),
    .dir     (dir),
    .q       (r3_q),
    .q_next  (r3_next)
  );

  jpg_twisted_ring #(.W(PH4_STAGES)) u_ring2 (
    .clk     (clk),
    .rst     (rst),
    .step_en (step_en),
    .dir     (dir),
    .q       (r2_q),
    .q_next  (r2_next)
  );

  // Decoding the next pattern lets the strobes be registered in step with the ring.
  jpg_state_decode #(.W(STAGES)) u_main_dec (
    .v   (main_next),
    .hit (main_hit)
  );

  jpg_state_decode #(.W(PH4_STAGES)) u_quad_dec (
    .v   (r2_next),
    .hit (r2_hit)
  );

  // First stage, last stage and inverted middle stage are two positions apart.
  assign ph3_d = {~r3_next[1], r3_next[2], r3_next[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe <= POSITIONS'(1);
      phase3 <= 3'b100;
      phase4 <= 4'b0001;
    end else if (step_en) begin
      strobe <= main_hit;
      phase3 <= ph3_d;
      phase4 <= r2_hit;
    end
  end

  assign count = main_q;
endmodule

// File: rtl/jpg_checker.sv
module jpg_checker #(
  parameter int STAGES = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                step_en,
  input logic                dir,
  input logic [STAGES-1:0]   count,
  input logic [2*STAGES-1:0] strobe,
  input logic [2:0]          phase3,
  input logic [3:0]          phase4
);
  logic [STAGES-1:0] cnt_inv;
  logic              cnt_legal;
  assign cnt_inv   = ~count;
  assign cnt_legal = ((count & (count + 1'b1)) == '0) ||
                     ((cnt_inv & (cnt_inv + 1'b1)) == '0);

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (count == '0) && (strobe == (2*STAGES)'(1)) &&
            (phase3 == 3'b100) && (phase4 == 4'b0001));

  p_fwd_shift_r2: assert property (@(posedge clk) disable iff (rst)
    (step_en && dir) |=>
      count == {$past(count[STAGES-2:0]), ~$past(count[STAGES-1])});

  p_rev_shift_r3: assert property (@(posedge clk) disable iff (rst)
    (step_en && !dir) |=>
      count == {~$past(count[0]), $past(count[STAGES-1:1])});

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(count) && $stable(strobe) &&
                 $stable(phase3) && $stable(phase4));

  p_strobe_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $countones(strobe) == 1);

  p_strobe_zero_r5: assert property (@(posedge clk) disable iff (rst)
    strobe[0] == (count == '0));

  p_phase3_width_r6: assert property (@(posedge clk) disable iff (rst)
    ($countones(phase3) >= 1) && ($countones(phase3) <= 2));

  p_phase4_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $countones(phase4) == 1);

  p_legal_r8: assert property (@(posedge clk) disable iff (rst)
    cnt_legal);
endmodule

bind johnson_phase_gen jpg_checker #(.STAGES(STAGES)) u_jpg_checker (
  .clk     (clk),
  .rst     (rst),
  .step_en (step_en),
  .dir     (dir),
  .count   (count),
  .strobe  (strobe),
  .phase3  (phase3),
  .phase4  (phase4)
);

// File: tb/johnson_phase_gen_test.sv
module johnson_phase_gen_test;
  localparam int N  = 4;
  localparam int NP = 2 * N;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          step_en = 1'b0;
  logic          dir = 1'b1;
  logic [N-1:0]  count;
  logic [NP-1:0] strobe;
  logic [2:0]    phase3;
  logic [3:0]    phase4;

  typedef struct {
    logic [N-1:0]  c;
    logic [NP-1:0] s;
    logic [2:0]    p3;
    logic [3:0]    p4;
    string         tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  int pos = 0;
  int pos3 = 0;
  int pos4 = 0;
  bit done = 1'b0;

  always #10ns clk = ~clk;

  johnson_phase_gen #(.STAGES(N)) uut (
    .clk     (clk),
    .rst     (rst),
    .step_en (step_en),
    .dir     (dir),
    .count   (count),
    .strobe  (strobe),
    .phase3  (phase3),
    .phase4  (phase4)
  );

  function automatic logic [N-1:0] ring_pattern(int p);
    if (p <= N) return N'((1 << p) - 1);
    return ~N'((1 << (p - N)) - 1);
  endfunction

  function automatic logic [2:0] tri_wave(int p);
    logic [2:0] w;
    w[0] = (p >= 1) && (p <= 3);
    w[1] = (p >= 3) && (p <= 5);
    w[2] = (p == 5) || (p <= 1);
    return w;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of inputs and queues the outputs expected after the edge.
  task automatic drive(bit r, bit en, bit d, string tag);
    exp_t e;
    @(negedge clk);
    rst = r;
    step_en = en;
    dir = d;
    if (r) begin
      pos = 0; pos3 = 0; pos4 = 0;
    end else if (en) begin
      if (d) begin
        pos = (pos + 1) % NP; pos3 = (pos3 + 1) % 6; pos4 = (pos4 + 1) % 4;
      end else begin
        pos = (pos + NP - 1) % NP; pos3 = (pos3 + 5) % 6; pos4 = (pos4 + 3) % 4;
      end
    end
    e.c   = ring_pattern(pos);
    e.s   = NP'(1) << pos;
    e.p3  = tri_wave(pos3);
    e.p4  = 4'(1) << pos4;
    e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compares each queued item one step after the edge it belongs to.
  exp_t got;
  always @(posedge clk) begin
    #1ns;
    if (sb.size() > 0) begin
      bit stepping;
      bit legal;
      got = sb.pop_front();
      stepping = (got.tag == "R2") || (got.tag == "R3");
      check(count == got.c, got.tag, "count", int'(count), int'(got.c));
      check(strobe == got.s, stepping ? "R5" : got.tag, "strobe", int'(strobe), int'(got.s));
      check(phase3 == got.p3, stepping ? "R6" : got.tag, "phase3", int'(phase3), int'(got.p3));
      check(phase4 == got.p4, stepping ? "R7" : got.tag, "phase4", int'(phase4), int'(got.p4));
      legal = 1'b0;
      for (int p = 0; p < NP; p++) begin
        if (count == ring_pattern(p)) legal = 1'b1;
      end
      check(legal, "R8", "legal pattern", int'(count), 0);
    end
  end

  initial begin
    #4ms;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    drive(1, 0, 1, "R1");
    drive(1, 1, 0, "R1");
    // forward past a full wrap
    for (int i = 0; i < NP + 3; i++) drive(0, 1, 1, "R2");
    // idle with dir moving
    drive(0, 0, 0, "R4");
    drive(0, 0, 1, "R4");
    drive(0, 0, 0, "R4");
    // reverse through zero
    for (int i = 0; i < NP + 2; i++) drive(0, 1, 0, "R3");
    // alternating directions and gaps
    for (int i = 0; i < 6; i++) begin
      drive(0, 1, i[0], i[0] ? "R2" : "R3");
      drive(0, 1, 1, "R2");
      drive(0, 0, i[1], "R4");
    end
    // reset while stepping
    drive(1, 1, 1, "R1");
    drive(0, 1, 0, "R3");
    drive(0, 1, 0, "R3");
    drive(0, 1, 1, "R2");
    for (int i = 0; i < 5; i++) drive(0, 1, 1, "R2");
    drive(0, 0, 1, "R4");
    @(posedge clk);
    #2ns;
    @(posedge clk);
    #2ns;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule